// File: doc/BRIEF.md
# Per-Line DMA Request Tracker

This block sits between a DMA request source and a memory directory. It takes load and store requests, works out the cache-line address of each, and sends each request to the directory as a message. It keeps a small table of outstanding transactions with one entry per line address, so several different lines can be in flight at once. Each request message leaves a fixed number of cycles after the request is accepted. Directory responses are matched to their entry by line address. A read-data response or a write acknowledge frees the entry and produces a completion for the requester.

A request to a line that already has a transaction in flight is accepted into a small park queue instead of being sent. Every completion wakes the whole park queue. The parked requests are then tried again in the order they arrived. A request whose line is still busy goes back to the tail of the queue and waits for the next completion. Malformed request or response kinds are dropped and recorded in sticky error flags. Responses that do not fit the table are dropped and recorded in a separate sticky protocol flag.

Top module: `dma_line_tracker`

## Requirements
- R1: After reset, `req_ready` is 1 and `out_valid`, `done_valid`, `err_req`, `err_rsp` and `err_proto` are all 0.
- R2: A load request (`req_kind` = 2'b00) to a line with no open entry produces one message with `out_write` = 0. The message carries the request's address, line (`req_paddr[AW-1:OFF]`), data, length and `out_src` = SRC_ID. `out_valid` is high exactly SEND_LAT cycles after the cycle of acceptance.
- R3: A store request (`req_kind` = 2'b01) to a free line produces a message with `out_write` = 1. The message carries the store data and byte length and has the same latency as R2.
- R4: Messages leave in the order in which their requests were launched.
- R5: A response with `rsp_kind` = 2'b01 (data) for a line with an open read gives `done_valid` = 1 and `done_write` = 0 in the following cycle, with the response's line and data. The entry is freed.
- R6: A response with `rsp_kind` = 2'b10 (acknowledge) for a line with an open write gives `done_valid` = 1 and `done_write` = 1 in the following cycle. The entry is freed.
- R7: A request to a line with an open entry is accepted but not sent. It is parked until a completion, and parked requests are then retried in their arrival order.
- R8: A parked request whose line is still busy when it is retried stays parked. It is sent only after a later completion frees its line.
- R9: While all NENT entries are open, `req_ready` is 0. It returns to 1 after a completion.
- R10: A request kind other than 2'b00 or 2'b01 is consumed and sends nothing. It sets the sticky flag `err_req`.
- R11: A response kind other than 2'b01 or 2'b10 produces no completion and sets the sticky flag `err_rsp`. It does not set `err_proto`.
- R12: A data or acknowledge response whose line has no open entry, or whose kind does not match the entry (data for a write), is dropped and sets the sticky flag `err_proto`. An entry hit by a mismatched response stays open.
- R13: Up to NENT different lines can be outstanding at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | 00 load, 01 store, others invalid |
| req_paddr | input | AW | Physical byte address |
| req_data | input | DW | Store data block |
| req_len | input | LW | Byte length |
| out_valid | output | 1 | Message to directory valid |
| out_write | output | 1 | 1 write message, 0 read message |
| out_paddr | output | AW | Physical address |
| out_line | output | AW-OFF | Line address |
| out_data | output | DW | Data block |
| out_len | output | LW | Byte length |
| out_src | output | IDW | Requester identifier |
| rsp_valid | input | 1 | Directory response present (always consumed) |
| rsp_kind | input | 2 | 01 data, 10 acknowledge, others invalid |
| rsp_line | input | AW-OFF | Line address of the response |
| rsp_data | input | DW | Returned data block |
| done_valid | output | 1 | Completion to requester |
| done_write | output | 1 | 1 write completion, 0 read completion |
| done_line | output | AW-OFF | Completed line |
| done_data | output | DW | Read data, zero for writes |
| err_req | output | 1 | Sticky: invalid request kind seen |
| err_rsp | output | 1 | Sticky: invalid response kind seen |
| err_proto | output | 1 | Sticky: unmatched or mismatched response |

## Verification
Single loads and stores to idle lines show whether the message fields and the fixed latency are right. A burst of four loads to distinct lines fills the table, which shows issue order and the back-pressure at capacity. Same-line conflicts are tried three ways: one parked request behind a single busy line; two parked requests where the completion frees only the second one's line, so the first must go back to the queue; and two parked requests to one line where the first replay makes the line busy again for the second. Malformed kinds, a response for an absent line, and a data response against an open write tell the three error flags apart. They also show that a mismatched response leaves its entry open.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

    typedef enum logic [1:0] {
        RK_LOAD  = 2'b00,
        RK_STORE = 2'b01
    } req_kind_e;

    typedef enum logic [1:0] {
        RSP_DATA = 2'b01,
        RSP_ACK  = 2'b10
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ES_IDLE    = 2'b00,
        ES_RD_OPEN = 2'b01,
        ES_WR_OPEN = 2'b10
    } ent_state_e;

    function automatic logic req_kind_ok(input logic [1:0] k);
        return (k == RK_LOAD) || (k == RK_STORE);
    endfunction

    function automatic logic rsp_kind_ok(input logic [1:0] k);
        return (k == RSP_DATA) || (k == RSP_ACK);
    endfunction

endpackage

// File: rtl/dlt_entry_table.sv
module dlt_entry_table #(
    parameter int NENT  = 4,
    parameter int LINEW = 12,
    localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    alloc_en,
    input  logic                    alloc_wr,
    input  logic [LINEW-1:0]        alloc_line,
    input  logic                    free_en,
    input  logic [IW-1:0]           free_idx,
    input  logic [LINEW-1:0]        q_line,
    output logic                    q_hit,
    input  logic [LINEW-1:0]        r_line,
    output logic                    r_hit,
    output logic [IW-1:0]           r_idx,
    output dlt_pkg::ent_state_e     r_state,
    output logic                    full
);
    import dlt_pkg::*;

    ent_state_e       st [NENT];
    logic [LINEW-1:0] ln [NENT];
    logic [NENT-1:0]  busy;
    logic [IW-1:0]    alloc_idx;

    for (genvar g = 0; g < NENT; g++) begin : g_ent
        assign busy[g] = (st[g] != ES_IDLE);
        always_ff @(posedge clk) begin
            if (rst) begin
                st[g] <= ES_IDLE;
                ln[g] <= '0;
            end else if (free_en && (free_idx == IW'(g))) begin
                st[g] <= ES_IDLE;
            end else if (alloc_en && (alloc_idx == IW'(g))) begin
                st[g] <= alloc_wr ? ES_WR_OPEN : ES_RD_OPEN;
                ln[g] <= alloc_line;
            end
        end
    end

    assign full = &busy;

    // lowest idle entry takes the next allocation
    always_comb begin
        alloc_idx = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (!busy[i]) alloc_idx = IW'(i);
        end
    end

    always_comb begin
        q_hit   = 1'b0;
        r_hit   = 1'b0;
        r_idx   = '0;
        r_state = ES_IDLE;
        for (int i = 0; i < NENT; i++) begin
            if (busy[i] && ln[i] == q_line) q_hit = 1'b1;
            if (busy[i] && ln[i] == r_line) begin
                r_hit   = 1'b1;
                r_idx   = IW'(i);
                r_state = st[i];
            end
        end
    end

    AST_ALLOC_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !full);                                          // R9
    AST_ALLOC_UNIQUE_LINE: assert property (@(posedge clk) disable iff (rst)
        (alloc_en && alloc_line == q_line) |-> !q_hit);               // R7
    AST_FREE_ONLY_OPEN: assert property (@(posedge clk) disable iff (rst)
        free_en |-> busy[free_idx]);                                  // R12

endmodule

// File: rtl/dlt_park_fifo.sv
module dlt_park_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_PK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> !full);                                    // R7
    AST_PK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);                                              // R8

endmodule

// File: rtl/dlt_send_pipe.sv
module dlt_send_pipe #(
    parameter int LAT = 6,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic [LAT-1:0] v;
    logic [W-1:0]   d [LAT];

    always_ff @(posedge clk) begin
        if (rst) v[0] <= 1'b0;
        else     v[0] <= in_valid;
        d[0] <= in_data;
    end

    for (genvar g = 1; g < LAT; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) v[g] <= 1'b0;
            else     v[g] <= v[g-1];
            d[g] <= d[g-1];
        end
    end

    assign out_valid = v[LAT-1];
    assign out_data  = d[LAT-1];

endmodule

// File: rtl/dma_line_tracker.sv
module dma_line_tracker #(
    parameter int NENT     = 4,
    parameter int PDEPTH   = 4,
    parameter int AW       = 16,
    parameter int OFF      = 4,
    parameter int DW       = 32,
    parameter int LW       = 4,
    parameter int IDW      = 8,
    parameter int SRC_ID   = 90,
    parameter int SEND_LAT = 6,
    localparam int LINEW   = AW - OFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [AW-1:0]    req_paddr,
    input  logic [DW-1:0]    req_data,
    input  logic [LW-1:0]    req_len,
    output logic             out_valid,
    output logic             out_write,
    output logic [AW-1:0]    out_paddr,
    output logic [LINEW-1:0] out_line,
    output logic [DW-1:0]    out_data,
    output logic [LW-1:0]    out_len,
    output logic [IDW-1:0]   out_src,
    input  logic             rsp_valid,
    input  logic [1:0]       rsp_kind,
    input  logic [LINEW-1:0] rsp_line,
    input  logic [DW-1:0]    rsp_data,
    output logic             done_valid,
    output logic             done_write,
    output logic [LINEW-1:0] done_line,
    output logic [DW-1:0]    done_data,
    output logic             err_req,
    output logic             err_rsp,
    output logic             err_proto
);
    import dlt_pkg::*;

    localparam int MW = 1 + AW + DW + LW;
    localparam int IW = (NENT > 1) ? $clog2(NENT) : 1;
    localparam int CW = $clog2(PDEPTH + 1);

    // ---------------- candidate selection ----------------
    logic [CW-1:0]    replay_cnt;
    logic             wake_pend;
    logic             from_park;
    logic             in_take;
    logic [MW-1:0]    pk_head, in_msg, cand_msg;
    logic [AW-1:0]    cand_paddr;
    logic [LINEW-1:0] cand_line;
    logic             cand_act, cand_bad, launch, park_push;
    logic             tbl_full, q_hit;
    logic [CW-1:0]    pk_count;
    logic             pk_full, pk_empty;

    assign from_park = (replay_cnt != '0);
    assign req_ready = !from_park && !wake_pend && !tbl_full && !pk_full;
    assign in_take   = req_valid && req_ready;

    assign in_msg     = {req_kind == RK_STORE, req_paddr, req_data, req_len};
    assign cand_msg   = from_park ? pk_head : in_msg;
    assign cand_paddr = cand_msg[MW-2 -: AW];
    assign cand_line  = cand_paddr[AW-1:OFF];

    assign cand_act  = from_park || in_take;
    assign cand_bad  = in_take && !req_kind_ok(req_kind);
    assign launch    = cand_act && !cand_bad && !q_hit && !tbl_full;
    assign park_push = cand_act && !cand_bad && !launch;

    // ---------------- response matching ----------------
    logic             r_hit;
    logic [IW-1:0]    r_idx;
    ent_state_e       r_state;
    logic             match_rd, match_wr, complete;

    assign match_rd = r_hit && (r_state == ES_RD_OPEN) && (rsp_kind == RSP_DATA);
    assign match_wr = r_hit && (r_state == ES_WR_OPEN) && (rsp_kind == RSP_ACK);
    assign complete = rsp_valid && (match_rd || match_wr);

    dlt_entry_table #(.NENT(NENT), .LINEW(LINEW)) u_table (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (launch),
        .alloc_wr   (cand_msg[MW-1]),
        .alloc_line (cand_line),
        .free_en    (complete),
        .free_idx   (r_idx),
        .q_line     (cand_line),
        .q_hit      (q_hit),
        .r_line     (rsp_line),
        .r_hit      (r_hit),
        .r_idx      (r_idx),
        .r_state    (r_state),
        .full       (tbl_full)
    );

    dlt_park_fifo #(.DEPTH(PDEPTH), .W(MW)) u_park (
        .clk   (clk),
        .rst   (rst),
        .push  (park_push),
        .din   (cand_msg),
        .pop   (from_park),
        .dout  (pk_head),
        .count (pk_count),
        .full  (pk_full),
        .empty (pk_empty)
    );

    logic [MW-1:0] snd_msg;

    dlt_send_pipe #(.LAT(SEND_LAT), .W(MW)) u_send (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (launch),
        .in_data   (cand_msg),
        .out_valid (out_valid),
        .out_data  (snd_msg)
    );

    assign {out_write, out_paddr, out_data, out_len} = snd_msg;
    assign out_line = out_paddr[AW-1:OFF];
    assign out_src  = IDW'(SRC_ID);

    // ---------------- replay control ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            replay_cnt <= '0;
            wake_pend  <= 1'b0;
        end else begin
            if (from_park)      replay_cnt <= replay_cnt - 1'b1;
            else if (wake_pend) replay_cnt <= pk_count;
            if (complete)                   wake_pend <= 1'b1;
            else if (!from_park && wake_pend) wake_pend <= 1'b0;
        end
    end

    // ---------------- completion and error flags ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            done_valid <= 1'b0;
            done_write <= 1'b0;
            done_line  <= '0;
            done_data  <= '0;
            err_req    <= 1'b0;
            err_rsp    <= 1'b0;
            err_proto  <= 1'b0;
        end else begin
            done_valid <= complete;
            done_write <= match_wr;
            done_line  <= rsp_line;
            done_data  <= match_rd ? rsp_data : '0;
            if (cand_bad) err_req <= 1'b1;
            if (rsp_valid && !rsp_kind_ok(rsp_kind)) err_rsp <= 1'b1;
            if (rsp_valid && rsp_kind_ok(rsp_kind) && !complete) err_proto <= 1'b1;
        end
    end

    AST_DONE_NEEDS_RSP: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> $past(rsp_valid));                             // R5
    AST_ERR_REQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_req |=> err_req);                                         // R10
    AST_PARK_NOT_EMPTY_ON_REPLAY: assert property (@(posedge clk) disable iff (rst)
        from_park |-> !pk_empty);                                     // R8
    AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (tbl_full && req_valid) |-> !launch);                         // R9

endmodule

// File: tb/dma_line_tracker_tb.sv
module dma_line_tracker_tb;
    localparam int LAT = 6;
    localparam int SRC = 90;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_paddr = '0;
    logic [31:0] req_data = '0;
    logic [3:0]  req_len = '0;
    logic        out_valid, out_write;
    logic [15:0] out_paddr;
    logic [11:0] out_line;
    logic [31:0] out_data;
    logic [3:0]  out_len;
    logic [7:0]  out_src;
    logic        rsp_valid = 1'b0;
    logic [1:0]  rsp_kind = 2'b00;
    logic [11:0] rsp_line = '0;
    logic [31:0] rsp_data = '0;
    logic        done_valid, done_write;
    logic [11:0] done_line;
    logic [31:0] done_data;
    logic        err_req, err_rsp, err_proto;

    dma_line_tracker u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_paddr(req_paddr), .req_data(req_data), .req_len(req_len),
        .out_valid(out_valid), .out_write(out_write), .out_paddr(out_paddr),
        .out_line(out_line), .out_data(out_data), .out_len(out_len), .out_src(out_src),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_line(rsp_line), .rsp_data(rsp_data),
        .done_valid(done_valid), .done_write(done_write), .done_line(done_line),
        .done_data(done_data),
        .err_req(err_req), .err_rsp(err_rsp), .err_proto(err_proto)
    );

    always #4 clk = ~clk;   // 125 MHz

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        bit          wr;
        logic [15:0] paddr;
        logic [31:0] data;
        logic [3:0]  len;
        int          acc;
        bit          chk_lat;
        string       tag;
    } out_item_t;

    typedef struct {
        bit          wr;
        logic [11:0] line;
        logic [31:0] data;
        string       tag;
    } done_item_t;

    out_item_t  exp_out [$];
    done_item_t exp_done [$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exp_out.size() == 0) begin
                    chk(1'b0, "R7", "unexpected message paddr", 64'(out_paddr), 64'hFFFF);
                end else begin
                    out_item_t e;
                    e = exp_out.pop_front();
                    chk(out_write == e.wr, e.tag, "out_write", 64'(out_write), 64'(e.wr));
                    chk(out_paddr == e.paddr, e.tag, "out_paddr", 64'(out_paddr), 64'(e.paddr));
                    chk(out_line == e.paddr[15:4], e.tag, "out_line", 64'(out_line), 64'(e.paddr[15:4]));
                    chk(out_data == e.data, e.tag, "out_data", 64'(out_data), 64'(e.data));
                    chk(out_len == e.len, e.tag, "out_len", 64'(out_len), 64'(e.len));
                    chk(out_src == 8'(SRC), e.tag, "out_src", 64'(out_src), 64'(SRC));
                    if (e.chk_lat)
                        chk(cyc - e.acc == LAT, e.tag, "latency", 64'(cyc - e.acc), 64'(LAT));
                end
            end
            if (done_valid) begin
                if (exp_done.size() == 0) begin
                    chk(1'b0, "R12", "unexpected completion line", 64'(done_line), 64'hFFF);
                end else begin
                    done_item_t d;
                    d = exp_done.pop_front();
                    chk(done_write == d.wr, d.tag, "done_write", 64'(done_write), 64'(d.wr));
                    chk(done_line == d.line, d.tag, "done_line", 64'(done_line), 64'(d.line));
                    chk(done_data == d.data, d.tag, "done_data", 64'(done_data), 64'(d.data));
                end
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic push_out(input bit wr, input logic [15:0] pa, input logic [31:0] dt,
                            input logic [3:0] ln, input int acc, input bit lat, input string tag);
        out_item_t e;
        e.wr = wr; e.paddr = pa; e.data = dt; e.len = ln;
        e.acc = acc; e.chk_lat = lat; e.tag = tag;
        exp_out.push_back(e);
    endtask

    task automatic send_req(input logic [1:0] kind, input logic [15:0] pa,
                            input logic [31:0] dt, input logic [3:0] ln,
                            input bit parked, input string tag);
        req_valid = 1'b1;
        req_kind  = kind;
        req_paddr = pa;
        req_data  = dt;
        req_len   = ln;
        while (!req_ready) @(negedge clk);
        if (!parked && kind <= 2'b01)
            push_out(kind == 2'b01, pa, dt, ln, cyc, 1'b1, tag);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_rsp(input logic [1:0] kind, input logic [11:0] line,
                            input logic [31:0] dt, input bit expect_done,
                            input bit wr, input string tag);
        rsp_valid = 1'b1;
        rsp_kind  = kind;
        rsp_line  = line;
        rsp_data  = dt;
        if (expect_done) begin
            done_item_t d;
            d.wr = wr; d.line = line; d.data = wr ? 32'h0 : dt; d.tag = tag;
            exp_done.push_back(d);
        end
        @(posedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
        chk(out_valid == 1'b0, "R1", "out_valid", 64'(out_valid), 64'd0);
        chk(done_valid == 1'b0, "R1", "done_valid", 64'(done_valid), 64'd0);
        chk({err_req, err_rsp, err_proto} == 3'b000, "R1", "error flags",
            64'({err_req, err_rsp, err_proto}), 64'd0);

        // R2, R3: single load and store
        send_req(2'b00, 16'h0104, 32'hA5A5_0001, 4'd4, 1'b0, "R2");
        send_req(2'b01, 16'h0208, 32'hDEAD_BEEF, 4'd8, 1'b0, "R3");
        idle(10);
        // R5, R6: matching completions
        send_rsp(2'b01, 12'h010, 32'h1111_2222, 1'b1, 1'b0, "R5");
        send_rsp(2'b10, 12'h020, 32'h0, 1'b1, 1'b1, "R6");
        idle(4);

        // R4, R13: four distinct lines, then R9 table full
        for (int i = 0; i < 4; i++)
            send_req(2'b00, 16'h0300 + 16'(i * 16), 32'h3000 + 32'(i), 4'(i + 1), 1'b0, "R4");
        chk(req_ready == 1'b0, "R9", "req_ready with table full", 64'(req_ready), 64'd0);
        idle(8);
        send_rsp(2'b01, 12'h030, 32'hC0DE_0030, 1'b1, 1'b0, "R13");
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "req_ready after completion", 64'(req_ready), 64'd1);
        for (int i = 1; i < 4; i++)
            send_rsp(2'b01, 12'h030 + 12'(i), 32'hC0DE_0030 + 32'(i), 1'b1, 1'b0, "R13");
        idle(4);

        // R7: one parked request behind a busy line
        send_req(2'b01, 16'h0400, 32'h4040_4040, 4'd2, 1'b0, "R3");
        send_req(2'b00, 16'h0404, 32'h0, 4'd1, 1'b1, "R7");
        send_req(2'b00, 16'h0410, 32'h0, 4'd3, 1'b0, "R7");
        idle(12);
        send_rsp(2'b10, 12'h040, 32'h0, 1'b1, 1'b1, "R6");
        push_out(1'b0, 16'h0404, 32'h0, 4'd1, 0, 1'b0, "R7");
        idle(12);
        send_rsp(2'b01, 12'h040, 32'h0404_0404, 1'b1, 1'b0, "R7");
        send_rsp(2'b01, 12'h041, 32'h0410_0410, 1'b1, 1'b0, "R5");
        idle(4);

        // R8: first parked request still conflicts on replay
        send_req(2'b01, 16'h0500, 32'h5000, 4'd1, 1'b0, "R3");
        send_req(2'b01, 16'h0510, 32'h5100, 4'd1, 1'b0, "R3");
        send_req(2'b00, 16'h0504, 32'h0, 4'd5, 1'b1, "R8");
        send_req(2'b00, 16'h0514, 32'h0, 4'd6, 1'b1, "R8");
        idle(10);
        send_rsp(2'b10, 12'h051, 32'h0, 1'b1, 1'b1, "R6");
        push_out(1'b0, 16'h0514, 32'h0, 4'd6, 0, 1'b0, "R8");
        idle(14);
        send_rsp(2'b10, 12'h050, 32'h0, 1'b1, 1'b1, "R6");
        push_out(1'b0, 16'h0504, 32'h0, 4'd5, 0, 1'b0, "R8");
        idle(12);
        send_rsp(2'b01, 12'h051, 32'h5151, 1'b1, 1'b0, "R8");
        send_rsp(2'b01, 12'h050, 32'h5050, 1'b1, 1'b0, "R8");
        idle(4);

        // R7: arrival order of two parked requests to one line
        send_req(2'b01, 16'h0600, 32'h6000, 4'd1, 1'b0, "R3");
        send_req(2'b00, 16'h0608, 32'h0, 4'd7, 1'b1, "R7");
        send_req(2'b01, 16'h060C, 32'h6666, 4'd2, 1'b1, "R7");
        idle(10);
        send_rsp(2'b10, 12'h060, 32'h0, 1'b1, 1'b1, "R6");
        push_out(1'b0, 16'h0608, 32'h0, 4'd7, 0, 1'b0, "R7");
        idle(14);
        send_rsp(2'b01, 12'h060, 32'h6060, 1'b1, 1'b0, "R7");
        push_out(1'b1, 16'h060C, 32'h6666, 4'd2, 0, 1'b0, "R7");
        idle(14);
        send_rsp(2'b10, 12'h060, 32'h0, 1'b1, 1'b1, "R7");
        idle(4);

        // R10: invalid request kind
        send_req(2'b10, 16'h0700, 32'h0, 4'd1, 1'b1, "R10");
        chk(err_req == 1'b1, "R10", "err_req", 64'(err_req), 64'd1);
        idle(10);

        // R11: invalid response kind
        send_rsp(2'b11, 12'h072, 32'h0, 1'b0, 1'b0, "R11");
        chk(err_rsp == 1'b1, "R11", "err_rsp", 64'(err_rsp), 64'd1);
        chk(err_proto == 1'b0, "R11", "err_proto stays low", 64'(err_proto), 64'd0);

        // R12: unmatched and mismatched responses
        send_rsp(2'b01, 12'h070, 32'h7070, 1'b0, 1'b0, "R12");
        chk(err_proto == 1'b1, "R12", "err_proto", 64'(err_proto), 64'd1);
        send_req(2'b01, 16'h0710, 32'h7171, 4'd3, 1'b0, "R3");
        idle(10);
        send_rsp(2'b01, 12'h071, 32'h9999, 1'b0, 1'b0, "R12");
        idle(3);
        send_rsp(2'b10, 12'h071, 32'h0, 1'b1, 1'b1, "R12");
        idle(6);

        chk(exp_out.size() == 0, "R4", "messages outstanding", 64'(exp_out.size()), 64'd0);
        chk(exp_done.size() == 0, "R5", "completions outstanding", 64'(exp_done.size()), 64'd0);
        chk(err_req == 1'b1, "R10", "err_req sticky", 64'(err_req), 64'd1);
        finish_run();
    end

endmodule